// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

The block takes two unrelated clocks, A and B, and passes one of them to its clock outputs. A change of source never produces a short high or low pulse. Each source has a gate, and a gate opens or closes only on that source's falling edge, while the source is low. A short chain of falling-edge flops in each source domain times the change. The old gate stays open for three more falling edges of the old clock. The new gate opens only after three falling edges of the new clock, and only once the old chain is completely empty.

A source can die while it is selected. An external detector reports this on a per-source stopped flag. When the flag of the source being left is high, that source's chain is cleared at once without waiting for its clock, so the output drops low immediately and only the acquire phase remains. Tying the A stopped flag to the select input gives automatic failover to B, and a return to A once A runs again.

Two output copies share one gated clock. Each copy has its own enable, and a disabled copy is held low.

Top module: `clk_failover_switch`

## Requirements
- R1: `sel_b` = 1 picks source B and `sel_b` = 0 picks source A. Once a switch is complete, the enabled outputs follow only the picked source.
- R2: When both sources run and the select changes, the output keeps following the old source. It goes low on the old source's third falling edge after the change.
- R3: After the old source has been released, the output stays low through three falling edges of the new source. From the next rising edge of the new source, it follows that source.
- R4: If the stopped flag of the source being left is high, that source's gate closes at once and the output goes low without waiting for any old-source edge. This holds for A and for B.
- R5: A switch away from a source that stopped high, or from one that stopped low, completes with the three-edge acquire of the new source.
- R6: The two gates are never open together, and no output pulse is shorter than the shorter half period of the two sources.
- R7: While a source is passed, each output high phase is as long as that source's high phase.
- R8: Output copy i carries the gated clock when `oe[i]` = 1 and is held low when `oe[i]` = 0. Enabled copies are identical.
- R9: When `sel_b` is tied to `stop_a`, a stop of A moves the output to B. When A restarts and its flag drops, the output returns to A through the normal release and acquire sequence.
- R10: While `rst` is high, both gates are closed and the outputs are low. After reset, the picked source is acquired with the three-edge sequence only.
- R11: If the select reverses during a switch, the gates still never overlap, and the output settles on the source selected last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Source clock A |
| clk_b | input | 1 | Source clock B |
| rst | input | 1 | Active-high reset, sampled on each source's falling edge |
| sel_b | input | 1 | Source select: 1 = B, 0 = A |
| stop_a | input | 1 | High when source A has been detected as stopped |
| stop_b | input | 1 | High when source B has been detected as stopped |
| oe | input | NUM_OUT | Per-copy output enable |
| clk_out | output | NUM_OUT | Gated output clock copies |

## Verification
The case of interest is a stopped flag rising in the same instant as the select change, which is the situation the failover tie creates. The stopped-clock bypass and the normal release then both act on one transition. The bench provokes this by freezing a source first high and then low, and afterwards raising its flag and flipping the select in one statement. It then requires the output to drop low at once and to start following the other source only after exactly three of that source's falling edges. A second collision, a select reversal while a release is still running, is judged by a behavioural model compared at every bench cycle and by a monitor that measures the width of every output pulse.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    localparam int unsigned HOLD_EDGES = 3;
    localparam int unsigned NUM_COPIES = 2;

    // Request seen by one source gate
    typedef struct packed {
        logic want;   // this source is the selected one
        logic kill;   // this source is being left and is known dead
    } src_ctl_t;

    // State reported by one source gate
    typedef struct packed {
        logic open;   // gate passes its clock
        logic busy;   // any stage of the timing chain is occupied
    } gate_st_t;

    function automatic src_ctl_t decode_ctl(input logic sel_b, input logic stopped, input src_e me);
        src_ctl_t c;
        c.want = (src_e'(sel_b) == me);
        c.kill = stopped & ~c.want;
        return c;
    endfunction

endpackage

// File: rtl/clksw_gate.sv
module clksw_gate
    import clksw_pkg::*;
#(
    parameter int unsigned STAGES = HOLD_EDGES
) (
    input  logic     clk_src,
    input  logic     rst,
    input  src_ctl_t ctl,
    input  logic     peer_busy,
    output gate_st_t st
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              kill;
    logic              admit;

    assign kill  = ctl.kill;
    // A new request enters only once the peer chain has fully drained
    assign admit = ctl.want & ~peer_busy;

    // Falling-edge chain: first stages resynchronise the request, the last drives the gate
    always_ff @(negedge clk_src or posedge kill) begin
        if (kill) begin
            chain <= '0;
        end else if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[LAST-1:0], admit};
        end
    end

    assign st.open = chain[LAST];
    assign st.busy = |chain;

    AST_KILL_CLOSES: assert property (@(negedge clk_src) disable iff (rst)
        kill |-> !st.open);  // R4

    AST_RESET_CLOSES: assert property (@(negedge clk_src)
        $past(rst) |-> !st.open);  // R10

endmodule

// File: rtl/clksw_merge.sv
module clksw_merge #(
    parameter int unsigned NUM_OUT = 2
) (
    input  logic               clk_a,
    input  logic               clk_b,
    input  logic               open_a,
    input  logic               open_b,
    input  logic [NUM_OUT-1:0] oe,
    output logic [NUM_OUT-1:0] clk_out
);

    logic muxed;

    // Gates change only while their own source is low, so the OR carries no runt
    assign muxed = (clk_a & open_a) | (clk_b & open_b);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_copy
        assign clk_out[i] = muxed & oe[i];
    end

endmodule

// File: rtl/clk_failover_switch.sv
module clk_failover_switch
    import clksw_pkg::*;
#(
    parameter int unsigned STAGES  = HOLD_EDGES,
    parameter int unsigned NUM_OUT = NUM_COPIES
) (
    input  logic               clk_a,
    input  logic               clk_b,
    input  logic               rst,
    input  logic               sel_b,
    input  logic               stop_a,
    input  logic               stop_b,
    input  logic [NUM_OUT-1:0] oe,
    output logic [NUM_OUT-1:0] clk_out
);

    src_ctl_t ctl_a;
    src_ctl_t ctl_b;
    gate_st_t st_a;
    gate_st_t st_b;

    assign ctl_a = decode_ctl(sel_b, stop_a, SRC_A);
    assign ctl_b = decode_ctl(sel_b, stop_b, SRC_B);

    clksw_gate #(.STAGES(STAGES)) u_gate_a (
        .clk_src   (clk_a),
        .rst       (rst),
        .ctl       (ctl_a),
        .peer_busy (st_b.busy),
        .st        (st_a)
    );

    clksw_gate #(.STAGES(STAGES)) u_gate_b (
        .clk_src   (clk_b),
        .rst       (rst),
        .ctl       (ctl_b),
        .peer_busy (st_a.busy),
        .st        (st_b)
    );

    clksw_merge #(.NUM_OUT(NUM_OUT)) u_merge (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .open_a  (st_a.open),
        .open_b  (st_b.open),
        .oe      (oe),
        .clk_out (clk_out)
    );

    AST_GATES_EXCLUSIVE_A: assert property (@(posedge clk_a) disable iff (rst)
        !(st_a.open && st_b.open));  // R6

    AST_GATES_EXCLUSIVE_B: assert property (@(posedge clk_b) disable iff (rst)
        !(st_a.open && st_b.open));  // R6

endmodule

// File: tb/clk_failover_switch_test.sv
`timescale 1ns/1ps
module clk_failover_switch_test;

    logic       clk = 1'b0;
    logic       clk_a, clk_b;
    logic       run_a = 1'b1, run_b = 1'b1;
    logic       rst = 1'b1, sel_b = 1'b0, stop_a = 1'b0, stop_b = 1'b0;
    logic [1:0] oe = 2'b11;
    logic [1:0] clk_out;

    int      checks = 0, errors = 0;
    string   tag = "R10";
    bit      cmp_on = 1'b0, mon_on = 1'b0, done = 1'b0;
    realtime last_edge = 0.0;

    always #10 clk = ~clk;  // 50 MHz bench clock

    // Source A: 30 ns period, falling edges at 20 + 30k
    initial begin
        clk_a = 1'b0;
        #5;
        forever begin
            if (run_a) clk_a = ~clk_a;
            #15;
        end
    end

    // Source B: 50 ns period, falling edges at 32 + 50k (never together with A)
    initial begin
        clk_b = 1'b0;
        #7;
        forever begin
            if (run_b) clk_b = ~clk_b;
            #25;
        end
    end

    clk_failover_switch uut (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .rst     (rst),
        .sel_b   (sel_b),
        .stop_a  (stop_a),
        .stop_b  (stop_b),
        .oe      (oe),
        .clk_out (clk_out)
    );

    // Behavioural reference: per source, a history of the last three requests
    bit   hist_a[$] = '{0, 0, 0};
    bit   hist_b[$] = '{0, 0, 0};
    bit   pass_a = 1'b0, pass_b = 1'b0;
    logic drop_a, drop_b;
    assign drop_a = stop_a & sel_b;
    assign drop_b = stop_b & ~sel_b;

    function automatic bit any_set(bit h[$]);
        foreach (h[k]) if (h[k]) return 1'b1;
        return 1'b0;
    endfunction

    always @(negedge clk_a or posedge drop_a) begin
        if (drop_a || rst) hist_a = '{0, 0, 0};
        else begin
            hist_a.push_back(!sel_b && !any_set(hist_b));
            void'(hist_a.pop_front());
        end
        pass_a = hist_a[0];
    end

    always @(negedge clk_b or posedge drop_b) begin
        if (drop_b || rst) hist_b = '{0, 0, 0};
        else begin
            hist_b.push_back(sel_b && !any_set(hist_a));
            void'(hist_b.pop_front());
        end
        pass_b = hist_b[0];
    end

    task automatic check(string t, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: clk_out got %b expected %b at %0t", t, act, exp, $time);
        end
    endtask

    task automatic check_int(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    // Compare against the model every bench cycle, away from all source edges
    always @(posedge clk) begin
        #14;
        if (cmp_on) check(tag, clk_out, {2{(clk_a & pass_a) | (clk_b & pass_b)}} & oe);
    end

    // Pulse width monitor on copy 0 (R6)
    always @(clk_out[0]) begin
        if (mon_on) begin
            checks++;
            if ($realtime - last_edge < 15.0) begin
                errors++;
                $display("FAIL R6: pulse width got %0t expected >= 15 ns at %0t", $realtime - last_edge, $time);
            end
            last_edge = $realtime;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic fall_a(int n);
        repeat (n) @(negedge clk_a);
    endtask

    task automatic fall_b(int n);
        repeat (n) @(negedge clk_b);
    endtask

    task automatic at_rise_a(string t, logic [1:0] exp);
        @(posedge clk_a);
        #3;
        check(t, clk_out, exp);
    endtask

    task automatic at_rise_b(string t, logic [1:0] exp);
        @(posedge clk_b);
        #3;
        check(t, clk_out, exp);
    endtask

    task automatic high_time(string t, int exp);
        realtime t0;
        @(posedge clk_out[0]);
        t0 = $realtime;
        @(negedge clk_out[0]);
        check_int(t, int'($realtime - t0), exp);
    endtask

    initial begin
        step(8);
        check("R10 reset", clk_out, 2'b00);
        step(2);
        rst = 1'b0;
        last_edge = $realtime;
        mon_on = 1'b1;
        cmp_on = 1'b1;
        fall_a(2);
        at_rise_a("R10 acquire early", 2'b00);
        fall_a(1);
        at_rise_a("R10 acquire done", 2'b11);

        // running switch A -> B
        step(5);
        tag = "R2";
        sel_b = 1'b1;
        fall_a(2);
        at_rise_a("R2 old still passed", 2'b11);
        fall_a(1);
        at_rise_a("R2 old released", 2'b00);
        tag = "R3";
        fall_b(2);
        at_rise_b("R3 hold low", 2'b00);
        fall_b(1);
        at_rise_b("R3 new passed", 2'b11);
        step(10);
        tag = "R1";
        @(negedge clk_b);
        #3;
        check("R1 B low phase", clk_out, 2'b00);
        at_rise_b("R1 B high phase", 2'b11);
        tag = "R7";
        high_time("R7 high phase B", 25);

        // running switch B -> A
        step(3);
        tag = "R2";
        sel_b = 1'b0;
        fall_b(3);
        at_rise_b("R2 B released", 2'b00);
        tag = "R3";
        fall_a(3);
        at_rise_a("R3 A passed", 2'b11);
        tag = "R7";
        high_time("R7 high phase A", 15);

        // reversal during a release
        step(3);
        tag = "R11";
        sel_b = 1'b1;
        fall_a(1);
        #3;
        sel_b = 1'b0;
        step(20);
        at_rise_a("R11 settled high", 2'b11);
        @(negedge clk_a);
        #3;
        check("R11 settled low", clk_out, 2'b00);

        // A stops high while selected, flag and select change together
        tag = "R5";
        @(posedge clk_a);
        #1;
        run_a = 1'b0;
        step(3);
        check("R5 A frozen high", clk_out, 2'b11);
        tag = "R4";
        stop_a = 1'b1;
        sel_b = 1'b1;
        #1;
        check("R4 immediate low A", clk_out, 2'b00);
        tag = "R5";
        fall_b(2);
        at_rise_b("R5 hold low after high stop", 2'b00);
        fall_b(1);
        at_rise_b("R5 B passed after high stop", 2'b11);

        // A restarts: failover tie returns to A
        tag = "R9";
        step(2);
        run_a = 1'b1;
        step(5);
        stop_a = 1'b0;
        sel_b = 1'b0;
        fall_b(3);
        at_rise_b("R9 B released", 2'b00);
        fall_a(3);
        at_rise_a("R9 back on A", 2'b11);

        // A stops low
        tag = "R5";
        @(negedge clk_a);
        #1;
        run_a = 1'b0;
        step(2);
        check("R5 A frozen low", clk_out, 2'b00);
        stop_a = 1'b1;
        sel_b = 1'b1;
        fall_b(2);
        at_rise_b("R5 hold low after low stop", 2'b00);
        fall_b(1);
        at_rise_b("R5 B passed after low stop", 2'b11);
        tag = "R9";
        run_a = 1'b1;
        step(5);
        stop_a = 1'b0;
        sel_b = 1'b0;
        step(30);
        at_rise_a("R9 A after low stop", 2'b11);

        // B stops high while selected
        sel_b = 1'b1;
        step(30);
        tag = "R4";
        @(posedge clk_b);
        #1;
        run_b = 1'b0;
        step(2);
        check("R4 B frozen high", clk_out, 2'b11);
        stop_b = 1'b1;
        sel_b = 1'b0;
        #1;
        check("R4 immediate low B", clk_out, 2'b00);
        fall_a(3);
        at_rise_a("R4 A passed after B stop", 2'b11);
        run_b = 1'b1;
        step(3);
        stop_b = 1'b0;
        step(10);

        // output copy enables
        tag = "R8";
        oe = 2'b01;
        step(2);
        at_rise_a("R8 copy 1 disabled", 2'b01);
        step(1);
        oe = 2'b11;
        step(2);
        at_rise_a("R8 copies match", 2'b11);
        step(5);

        cmp_on = 1'b0;
        mon_on = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL R10: watchdog got hung run expected completion at %0t", $time);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule